// File: doc/BRIEF.md
# Bus Activity Performance Counters

This block is a bus slave peripheral that watches two other bus master ports without driving them and counts what they do, one clock at a time. For each watched master it keeps two counters. One counts the cycles in which the master holds a request open, meaning its cycle and strobe are both high. The other counts the cycles in which that master's acknowledge is high. The two figures together show how much time a piece of code spends asking the bus for service and how much time it is actually being served.

Software reaches the four 32-bit counters through a Wishbone slave port in a four-word window. It reads them while profiling. Before a measurement it can write any value into them, either to clear them or to preload them. The system interconnect decodes the upper address bits, so the block itself looks only at the word offset. Every access on the slave port completes in the cycle it is presented. The block never stalls a transfer and never applies back-pressure to the requester.

Top module: `perfmon_top`

## Requirements
- R1: A synchronous active-high reset sets all four counters to zero at the next rising edge.
- R2: `wbs_ack_o` is high in exactly the cycles in which `wbs_cyc_i` and `wbs_stb_i` are both high, combinationally and with no wait states. If only one of the two is high, the acknowledge stays low.
- R3: Address bits [3:2] select the counter: 0 is master 0 requests, 1 is master 0 acknowledges, 2 is master 1 requests, and 3 is master 1 acknowledges. All other address bits are ignored.
- R4: A request counter increments by one at each rising edge where its master's `mon_cyc_i` and `mon_stb_i` bits are both high. Either bit high on its own does not count.
- R5: An acknowledge counter increments by one at each rising edge where its master's `mon_ack_i` bit is high, whatever that master's cycle and strobe bits are.
- R6: In a cycle with `wbs_cyc_i`, `wbs_stb_i` and `wbs_we_i` all high, the selected counter takes `wbs_dat_i` at the rising edge. The other counters carry on counting as usual.
- R7: When a write and an increment hit the same counter in the same cycle, the written value wins and the increment is lost.
- R8: A counter that increments from 0xFFFFFFFF becomes 0 and raises no flag.
- R9: During a read cycle, `wbs_dat_o` shows the selected counter's value from before that cycle's increment. A read changes no counter.
- R10: A cycle with `wbs_we_i` high but without both `wbs_cyc_i` and `wbs_stb_i` high writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the slave port and the watched masters |
| rst | input | 1 | Synchronous reset, active high |
| wbs_adr_i | input | ADDR_W (32) | Slave byte address; only bits [3:2] are decoded |
| wbs_dat_i | input | DATA_W (32) | Slave write data |
| wbs_we_i | input | 1 | Slave write enable |
| wbs_cyc_i | input | 1 | Slave bus cycle |
| wbs_stb_i | input | 1 | Slave strobe |
| wbs_ack_o | output | 1 | Slave acknowledge, zero wait states |
| wbs_dat_o | output | DATA_W (32) | Selected counter value |
| mon_cyc_i | input | NUM_MON (2) | Cycle signal of each watched master |
| mon_stb_i | input | NUM_MON (2) | Strobe signal of each watched master |
| mon_ack_i | input | NUM_MON (2) | Acknowledge signal seen by each watched master |

## Verification
The assertions assume that reset is applied at start-up. They also assume that all inputs are sampled at the rising clock edge and hold known values there, and that the watched-master bits may change freely from cycle to cycle. The stimulus drives every input on the falling edge, so each value is settled well before the next rising edge. The sweep walks all 64 combinations of the six watched-master bits and then reads every counter back. Writes, including writes that collide with an increment, are driven with fully formed slave cycles. Separate cycles present the write enable with a partial strobe/cycle pair, and these test the rule that such a cycle does nothing.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

  // Event kind watched for each master; the value is the low bit of the
  // counter index, so the address map depends on this ordering.
  typedef enum logic {
    EV_REQ = 1'b0,
    EV_ACK = 1'b1
  } ev_kind_e;

  localparam int EVENTS_PER_MON = 2;

  // Counter index for a given master and event kind.
  function automatic int ctr_index(input int mon, input ev_kind_e kind);
    return mon * EVENTS_PER_MON + int'(kind);
  endfunction

endpackage

// File: rtl/perfmon_decode.sv
module perfmon_decode #(
  parameter int ADDR_W  = 32,
  parameter int NUM_CTR = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          adr_i,
  input  logic                       we_i,
  input  logic                       cyc_i,
  input  logic                       stb_i,
  output logic                       ack_o,
  output logic [$clog2(NUM_CTR)-1:0] sel_o,
  output logic [NUM_CTR-1:0]         wr_en_o
);

  localparam int SEL_W  = $clog2(NUM_CTR);
  localparam int WORD_LSB = 2;
  localparam int SEL_MSB  = WORD_LSB + SEL_W - 1;

  logic access;
  logic unused_adr_bits;

  assign access  = cyc_i && stb_i;
  assign ack_o   = access;
  assign sel_o   = adr_i[SEL_MSB:WORD_LSB];

  assign unused_adr_bits = ^{adr_i[ADDR_W-1:SEL_MSB+1], adr_i[WORD_LSB-1:0]};

  generate
    for (genvar k = 0; k < NUM_CTR; k++) begin : g_wr
      assign wr_en_o[k] = access && we_i && (sel_o == SEL_W'(k));
    end
  endgenerate

  // R6
  wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en_o));

  // R10
  no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(cyc_i && stb_i) |-> (wr_en_o == '0));

endmodule

// File: rtl/perfmon_events.sv
module perfmon_events
  import perfmon_pkg::*;
#(
  parameter int NUM_MON = 2
) (
  input  logic [NUM_MON-1:0]                cyc_i,
  input  logic [NUM_MON-1:0]                stb_i,
  input  logic [NUM_MON-1:0]                ack_i,
  output logic [NUM_MON*EVENTS_PER_MON-1:0] ev_o
);

  generate
    for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
      assign ev_o[ctr_index(m, EV_REQ)] = cyc_i[m] && stb_i[m];
      assign ev_o[ctr_index(m, EV_ACK)] = ack_i[m];
    end
  endgenerate

endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic [DATA_W-1:0] q_o
);

  localparam logic [DATA_W-1:0] MAX_VAL = '1;

  always_ff @(posedge clk) begin
    if (rst)         q_o <= '0;
    else if (load_i) q_o <= load_val_i;
    else if (inc_i)  q_o <= q_o + DATA_W'(1);
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q_o == '0));

  // R4, R5
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !load_i && q_o != MAX_VAL) |=> (q_o == $past(q_o) + DATA_W'(1)));

  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (q_o == $past(load_val_i)));

  // R8
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !load_i && q_o == MAX_VAL) |=> (q_o == '0));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !load_i) |=> $stable(q_o));

endmodule

// File: rtl/perfmon_rdmux.sv
module perfmon_rdmux #(
  parameter int DATA_W  = 32,
  parameter int NUM_CTR = 4
) (
  input  logic [NUM_CTR-1:0][DATA_W-1:0] ctr_i,
  input  logic [$clog2(NUM_CTR)-1:0]     sel_i,
  output logic [DATA_W-1:0]              dat_o
);

  localparam int SEL_W = $clog2(NUM_CTR);

  logic [NUM_CTR-1:0][DATA_W-1:0] gated;

  generate
    for (genvar k = 0; k < NUM_CTR; k++) begin : g_gate
      assign gated[k] = (sel_i == SEL_W'(k)) ? ctr_i[k] : '0;
    end
  endgenerate

  always_comb begin
    dat_o = '0;
    for (int k = 0; k < NUM_CTR; k++) dat_o = dat_o | gated[k];
  end

endmodule

// File: rtl/perfmon_top.sv
module perfmon_top
  import perfmon_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int NUM_MON = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  wbs_adr_i,
  input  logic [DATA_W-1:0]  wbs_dat_i,
  input  logic               wbs_we_i,
  input  logic               wbs_cyc_i,
  input  logic               wbs_stb_i,
  output logic               wbs_ack_o,
  output logic [DATA_W-1:0]  wbs_dat_o,
  input  logic [NUM_MON-1:0] mon_cyc_i,
  input  logic [NUM_MON-1:0] mon_stb_i,
  input  logic [NUM_MON-1:0] mon_ack_i
);

  localparam int NUM_CTR = NUM_MON * EVENTS_PER_MON;
  localparam int SEL_W   = $clog2(NUM_CTR);

  logic [SEL_W-1:0]               sel;
  logic [NUM_CTR-1:0]             wr_en;
  logic [NUM_CTR-1:0]             ev;
  logic [NUM_CTR-1:0][DATA_W-1:0] ctr;

  perfmon_decode #(.ADDR_W(ADDR_W), .NUM_CTR(NUM_CTR)) u_decode (
    .clk     (clk),
    .rst     (rst),
    .adr_i   (wbs_adr_i),
    .we_i    (wbs_we_i),
    .cyc_i   (wbs_cyc_i),
    .stb_i   (wbs_stb_i),
    .ack_o   (wbs_ack_o),
    .sel_o   (sel),
    .wr_en_o (wr_en)
  );

  perfmon_events #(.NUM_MON(NUM_MON)) u_events (
    .cyc_i (mon_cyc_i),
    .stb_i (mon_stb_i),
    .ack_i (mon_ack_i),
    .ev_o  (ev)
  );

  generate
    for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
      perfmon_counter #(.DATA_W(DATA_W)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .inc_i      (ev[k]),
        .load_i     (wr_en[k]),
        .load_val_i (wbs_dat_i),
        .q_o        (ctr[k])
      );
    end
  endgenerate

  perfmon_rdmux #(.DATA_W(DATA_W), .NUM_CTR(NUM_CTR)) u_rdmux (
    .ctr_i (ctr),
    .sel_i (sel),
    .dat_o (wbs_dat_o)
  );

  // R2
  ack_needs_pair_chk: assert property (@(posedge clk) disable iff (rst)
    wbs_ack_o |-> (wbs_cyc_i && wbs_stb_i));

endmodule

// File: tb/perfmon_top_bench.sv
module perfmon_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] adr = '0;
  logic [31:0] dat_w = '0;
  logic        we = 1'b0, cyc = 1'b0, stb = 1'b0;
  logic        ack;
  logic [31:0] dat_r;
  logic [1:0]  m_cyc = '0, m_stb = '0, m_ack = '0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] expv [4];

  localparam logic [31:0] BASE = 32'h9900_0000;

  always #2 clk = ~clk;

  perfmon_top u_perfmon_top (
    .clk (clk), .rst (rst),
    .wbs_adr_i (adr), .wbs_dat_i (dat_w), .wbs_we_i (we),
    .wbs_cyc_i (cyc), .wbs_stb_i (stb), .wbs_ack_o (ack), .wbs_dat_o (dat_r),
    .mon_cyc_i (m_cyc), .mon_stb_i (m_stb), .mon_ack_i (m_ack)
  );

  // Reference model built from the requirements.
  always @(posedge clk) begin
    for (int k = 0; k < 4; k++) begin
      logic evk;
      evk = (k % 2 == 1) ? m_ack[k/2] : (m_cyc[k/2] && m_stb[k/2]);
      if (rst) expv[k] <= '0;
      else if (cyc && stb && we && adr[3:2] == 2'(k)) expv[k] <= dat_w;
      else if (evk) expv[k] <= expv[k] + 32'd1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] want);
    n_cmp++;
    if (act !== want) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, want);
    end
  endtask

  task automatic rd(input int k, input string tag);
    @(negedge clk);
    adr = BASE | 32'(k << 2); cyc = 1'b1; stb = 1'b1; we = 1'b0;
    #1;
    chk(tag, dat_r, expv[k]);
    chk("R2 ack on read", {31'd0, ack}, 32'd1);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    adr = a; dat_w = d; cyc = 1'b1; stb = 1'b1; we = 1'b1;
    #1;
    chk("R2 ack on write", {31'd0, ack}, 32'd1);
  endtask

  task automatic mon(input logic [5:0] p);
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    {m_cyc, m_stb, m_ack} = p;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: all counters zero after reset
    for (int k = 0; k < 4; k++) begin
      rd(k, "R1 reset value");
      chk("R1 reset value explicit", dat_r, 32'd0);
    end

    // R4 / R5: sweep every pattern of the watched-master bits
    for (int p = 0; p < 64; p++) begin
      mon(6'(p));
      mon(6'd0);
      for (int k = 0; k < 4; k++)
        rd(k, (k % 2 == 0) ? "R4 request count" : "R5 ack count");
    end

    // R2: partial strobe pairs give no acknowledge; R10: and no write
    @(negedge clk);
    v = expv[0];
    adr = BASE; dat_w = 32'hDEAD_BEEF; we = 1'b1; cyc = 1'b0; stb = 1'b1;
    #1 chk("R2 no ack without cyc", {31'd0, ack}, 32'd0);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b0;
    #1 chk("R2 no ack without stb", {31'd0, ack}, 32'd0);
    rd(0, "R10 partial write ignored");
    chk("R10 partial write explicit", dat_r, v);

    // R6: write each counter with distinct values
    for (int k = 0; k < 4; k++) wr(BASE | 32'(k << 2), 32'h1000_0000 * (k + 1) + 32'h55);
    for (int k = 0; k < 4; k++) begin
      rd(k, "R6 write load");
      chk("R6 write load explicit", dat_r, 32'h1000_0000 * (k + 1) + 32'h55);
    end

    // R7: write collides with increments on every counter
    @(negedge clk);
    m_cyc = 2'b11; m_stb = 2'b11; m_ack = 2'b11;
    wr(BASE | 32'h4, 32'h0000_0777);
    rd(1, "R7 load wins");
    chk("R7 load wins explicit", dat_r, 32'h0000_0777);
    rd(3, "R6 others keep counting");

    // R9: read returns pre-increment value, next cycle shows the step
    rd(0, "R9 read pre-increment");
    v = dat_r;
    rd(0, "R9 read next cycle");
    chk("R9 step after read", dat_r, v + 32'd1);
    mon(6'd0);

    // R3: upper and byte-lane address bits ignored
    wr(32'h7FFF_FFFB, 32'hA5A5_0003);
    rd(2, "R3 alias select");
    chk("R3 alias explicit", dat_r, 32'hA5A5_0003);
    wr(32'h0000_0003, 32'h0000_1234);
    rd(0, "R3 offset zero alias");

    // R8: wrap from all ones to zero
    wr(BASE | 32'h4, 32'hFFFF_FFFF);
    mon(6'b000001);
    mon(6'd0);
    rd(1, "R8 wrap");
    chk("R8 wrap explicit", dat_r, 32'd0);
    wr(BASE | 32'h8, 32'hFFFF_FFFF);
    mon(6'b101000);
    mon(6'd0);
    rd(2, "R8 wrap request");
    chk("R8 wrap request explicit", dat_r, 32'd0);

    summary();
  end

endmodule